// File: doc/BRIEF.md
# Receive Security-Association Table Access Controller

This block lets software fill and inspect three receive-side security-association tables through a handful of registers on a single-cycle register bus. The three tables hold SPI entries, key entries and IP-address entries. Software never addresses a table row directly. It first writes the values for one row into staging registers. It then writes a command word that names a table and a row and asks for a write or a read. On a write, the staged fields of that table go into the row. On a read, the row's fields come back into the staging registers, where the bus can read them.

The command word also holds the global engine-enable bit. That bit is driven out to the packet path. It stays as written until software writes the command register again, so every command write must carry the current enable value. A status register shows three things: a command is pending (busy), the last command has finished (done), and the last command was refused because its row was out of range (error). Table storage is not cleared by reset. Software clears it by writing zero into every row.

Register word addresses (4-bit `regAddr`):

| Address | Register |
|---|---|
| 0 | command |
| 1 | SPI |
| 2 | IP-table index |
| 3 to 6 | key words 0 to 3 |
| 7 | salt |
| 8 | mode |
| 9 to 12 | IP words 0 to 3 |
| 13 | status |

Top module: `sa_rx_table_access`

## Requirements
- R1: After reset, the command register, the status register and every staging register read as zero, and `engineEn` is 0.
- R2: Each staging register reads back the last value written to it. The mode register keeps only bits 4:0, which are valid (bit 0), ESP protocol (bit 2), decrypt (bit 3) and IPv6 (bit 4). Its upper bits read as zero. The IP-table index keeps 7 bits.
- R3: Command word layout is: bit 0 enable, bits 2:1 table code, bits 12:3 row, bit 30 read request, bit 31 write request. The table codes are 01 for the IP table, 10 for the SPI table and 11 for the key table. A write request stores the staging fields of the selected table into that row. The SPI table takes the SPI and the IP-table index. The key table takes the four key words, the salt and the mode. The IP table takes the four IP words.
- R4: A read request loads the selected row into that table's staging registers only. The staging registers of the other tables keep their values.
- R5: The request bits of a command are executed on the clock after the command write. Status reads busy (bit 0) during that one cycle. After it, both request bits read as zero and status shows done (bit 1).
- R6: When read and write are both requested, only the write is performed, and the staging registers are left unchanged.
- R7: An IP-table command whose row is 128 or more reaches no row, including the row equal to its low seven bits. Status then shows error (bit 2) together with done.
- R8: Table code 00 accesses no table. The staging registers are unchanged, and status shows done without error.
- R9: The enable bit drives `engineEn`. It stays as written when the command completes, and only a later command write changes it.
- R10: A command-register write that arrives while a command is pending is ignored.
- R11: Table contents survive a reset.
- R12: Rows of different tables, and different rows of one table, are stored independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| engineEn | output | 1 | Engine enable from the command register |

## Verification
The store-and-reload path is tried with a distinct pattern in each field. Each table is first written, then the staging registers are cleared, then the row is read back. This tells a correct load apart from a staging register that simply kept its old value. It also shows whether a read of one table disturbs another table's staging registers.

Rows that share a number across tables, and neighbouring rows of one table, show whether rows are stored apart. A command with both requests set separates write precedence from a read that overwrites staging. An IP row of 200 is tried against row 72, which has the same low seven bits. This separates a real range check from an index that is just truncated. A reset between write and read-back shows that storage is kept, while a second command written during the busy cycle shows it is ignored.

// File: rtl/sa_tbl_pkg.sv
package sa_tbl_pkg;

  localparam int ROW_W  = 10;  // row field width in the command word
  localparam int MODE_W = 5;   // kept mode bits

  typedef enum logic [1:0] {
    TBL_NONE = 2'b00,
    TBL_IP   = 2'b01,
    TBL_SPI  = 2'b10,
    TBL_KEY  = 2'b11
  } tblSel_e;

  localparam logic [3:0] ADDR_CMD   = 4'd0;
  localparam logic [3:0] ADDR_SPI   = 4'd1;
  localparam logic [3:0] ADDR_IPIDX = 4'd2;
  localparam logic [3:0] ADDR_KEY0  = 4'd3;
  localparam logic [3:0] ADDR_SALT  = 4'd7;
  localparam logic [3:0] ADDR_MODE  = 4'd8;
  localparam logic [3:0] ADDR_IP0   = 4'd9;
  localparam logic [3:0] ADDR_STAT  = 4'd13;

  // strobes from control to datapath, at most one action bit set
  typedef struct packed {
    logic             wrIp;
    logic             wrSpi;
    logic             wrKey;
    logic             ldIp;
    logic             ldSpi;
    logic             ldKey;
    logic [ROW_W-1:0] row;
  } tblOp_t;

endpackage

// File: rtl/sa_cmd_ctrl.sv
module sa_cmd_ctrl
  import sa_tbl_pkg::*;
#(
  parameter int SA_ROWS = 1024,
  parameter int IP_ROWS = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrEn,
  input  logic [14:0] cmdWord,   // {wr, rd, row[9:0], tbl[1:0], en}
  output tblOp_t      op,
  output logic [31:0] cmdView,
  output logic [31:0] statView,
  output logic        engineEn
);

  localparam logic [ROW_W:0] IP_LIM = (ROW_W+1)'(IP_ROWS);
  localparam logic [ROW_W:0] SA_LIM = (ROW_W+1)'(SA_ROWS);

  logic             enReg;
  tblSel_e          tblReg;
  logic [ROW_W-1:0] rowReg;
  logic             rdReq, wrReq, doneReg, errReg;
  logic             pending, cmdHit, rowOk, doWr, doRd;

  assign pending = rdReq | wrReq;
  assign cmdHit  = cmdWrEn && !pending;

  always_comb begin
    if (tblReg == TBL_IP) rowOk = {1'b0, rowReg} < IP_LIM;
    else                  rowOk = {1'b0, rowReg} < SA_LIM;
  end

  assign doWr = pending && wrReq && rowOk;
  assign doRd = pending && !wrReq && rdReq && rowOk;

  always_comb begin
    op       = '0;
    op.row   = rowReg;
    op.wrIp  = doWr && (tblReg == TBL_IP);
    op.wrSpi = doWr && (tblReg == TBL_SPI);
    op.wrKey = doWr && (tblReg == TBL_KEY);
    op.ldIp  = doRd && (tblReg == TBL_IP);
    op.ldSpi = doRd && (tblReg == TBL_SPI);
    op.ldKey = doRd && (tblReg == TBL_KEY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      tblReg  <= TBL_NONE;
      rowReg  <= '0;
      rdReq   <= 1'b0;
      wrReq   <= 1'b0;
      doneReg <= 1'b0;
      errReg  <= 1'b0;
    end else if (cmdHit) begin
      enReg   <= cmdWord[0];
      tblReg  <= tblSel_e'(cmdWord[2:1]);
      rowReg  <= cmdWord[12:3];
      rdReq   <= cmdWord[13];
      wrReq   <= cmdWord[14];
      doneReg <= 1'b0;
      errReg  <= 1'b0;
    end else if (pending) begin
      rdReq   <= 1'b0;
      wrReq   <= 1'b0;
      doneReg <= 1'b1;
      errReg  <= (tblReg != TBL_NONE) && !rowOk;
    end
  end

  assign engineEn = enReg;
  assign cmdView  = {wrReq, rdReq, 17'b0, rowReg, tblReg, enReg};
  assign statView = {29'b0, errReg, doneReg, pending};

  a_r5_strobe_clears: assert property (@(posedge clk) disable iff (!rstN)
    pending |=> !(rdReq || wrReq));
  a_r5_done_after: assert property (@(posedge clk) disable iff (!rstN)
    pending |=> doneReg);
  a_r9_enable_kept: assert property (@(posedge clk) disable iff (!rstN)
    (pending && $past(rstN)) |=> (engineEn == $past(engineEn)));
  a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (pending && cmdWrEn) |=> (rowReg == $past(rowReg) && tblReg == $past(tblReg)));
  a_r7_range_error: assert property (@(posedge clk) disable iff (!rstN)
    (pending && tblReg == TBL_IP && rowReg[ROW_W-1:7] != '0) |=> errReg);

endmodule

// File: rtl/sa_tbl_path.sv
module sa_tbl_path
  import sa_tbl_pkg::*;
#(
  parameter int SA_ROWS = 1024,
  parameter int IP_ROWS = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWdata,
  input  tblOp_t      op,
  output logic [31:0] stgView
);

  localparam int SAW = $clog2(SA_ROWS);
  localparam int IPW = $clog2(IP_ROWS);
  localparam logic [ROW_W:0] IP_LIM = (ROW_W+1)'(IP_ROWS);

  // staging registers
  logic [31:0]       spiStg, saltStg;
  logic [IPW-1:0]    ipIdxStg;
  logic [MODE_W-1:0] modeStg;
  logic [3:0][31:0]  keyStg, ipStg;

  // table storage, deliberately without reset
  logic [31:0]       spiMem   [SA_ROWS];
  logic [IPW-1:0]    ipIdxMem [SA_ROWS];
  logic [127:0]      keyMem   [SA_ROWS];
  logic [31:0]       saltMem  [SA_ROWS];
  logic [MODE_W-1:0] modeMem  [SA_ROWS];
  logic [127:0]      ipMem    [IP_ROWS];

  logic [SAW-1:0] saRow;
  logic [IPW-1:0] ipRow;
  assign saRow = op.row[SAW-1:0];
  assign ipRow = op.row[IPW-1:0];

  always_ff @(posedge clk) begin
    if (op.wrSpi) begin
      spiMem[saRow]   <= spiStg;
      ipIdxMem[saRow] <= ipIdxStg;
    end
    if (op.wrKey) begin
      keyMem[saRow]  <= keyStg;
      saltMem[saRow] <= saltStg;
      modeMem[saRow] <= modeStg;
    end
    if (op.wrIp) ipMem[ipRow] <= ipStg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spiStg   <= '0;
      saltStg  <= '0;
      ipIdxStg <= '0;
      modeStg  <= '0;
      keyStg   <= '0;
      ipStg    <= '0;
    end else begin
      if (regWrEn) begin
        if (regAddr == ADDR_SPI)   spiStg   <= regWdata;
        if (regAddr == ADDR_IPIDX) ipIdxStg <= regWdata[IPW-1:0];
        if (regAddr == ADDR_SALT)  saltStg  <= regWdata;
        if (regAddr == ADDR_MODE)  modeStg  <= regWdata[MODE_W-1:0];
        for (int k = 0; k < 4; k++) begin
          if (regAddr == ADDR_KEY0 + 4'(k)) keyStg[k] <= regWdata;
          if (regAddr == ADDR_IP0 + 4'(k))  ipStg[k]  <= regWdata;
        end
      end
      // a table load overrides a bus write in the same cycle
      if (op.ldSpi) begin
        spiStg   <= spiMem[saRow];
        ipIdxStg <= ipIdxMem[saRow];
      end
      if (op.ldKey) begin
        keyStg  <= keyMem[saRow];
        saltStg <= saltMem[saRow];
        modeStg <= modeMem[saRow];
      end
      if (op.ldIp) ipStg <= ipMem[ipRow];
    end
  end

  always_comb begin
    stgView = '0;
    if (regAddr == ADDR_SPI)   stgView = spiStg;
    if (regAddr == ADDR_IPIDX) stgView = 32'(ipIdxStg);
    if (regAddr == ADDR_SALT)  stgView = saltStg;
    if (regAddr == ADDR_MODE)  stgView = 32'(modeStg);
    for (int k = 0; k < 4; k++) begin
      if (regAddr == ADDR_KEY0 + 4'(k)) stgView = keyStg[k];
      if (regAddr == ADDR_IP0 + 4'(k))  stgView = ipStg[k];
    end
  end

  a_r6_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({op.wrIp, op.wrSpi, op.wrKey, op.ldIp, op.ldSpi, op.ldKey}));
  a_r7_ip_row_range: assert property (@(posedge clk) disable iff (!rstN)
    (op.wrIp || op.ldIp) |-> ({1'b0, op.row} < IP_LIM));
  a_r3_spi_stored: assert property (@(posedge clk) disable iff (!rstN)
    op.wrSpi |=> (spiMem[$past(saRow)] == $past(spiStg)));
  a_r6_write_keeps_staging: assert property (@(posedge clk) disable iff (!rstN)
    (op.wrSpi && !regWrEn) |=> $stable(spiStg));

endmodule

// File: rtl/sa_rx_table_access.sv
module sa_rx_table_access
  import sa_tbl_pkg::*;
#(
  parameter int SA_ROWS = 1024,
  parameter int IP_ROWS = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        engineEn
);

  tblOp_t      op;
  logic [31:0] cmdView, statView, stgView;

  sa_cmd_ctrl #(.SA_ROWS(SA_ROWS), .IP_ROWS(IP_ROWS)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrEn  (regWrEn && (regAddr == ADDR_CMD)),
    .cmdWord  ({regWdata[31:30], regWdata[12:0]}),
    .op       (op),
    .cmdView  (cmdView),
    .statView (statView),
    .engineEn (engineEn)
  );

  sa_tbl_path #(.SA_ROWS(SA_ROWS), .IP_ROWS(IP_ROWS)) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .op       (op),
    .stgView  (stgView)
  );

  always_comb begin
    if (regAddr == ADDR_CMD)       regRdata = cmdView;
    else if (regAddr == ADDR_STAT) regRdata = statView;
    else                           regRdata = stgView;
  end

endmodule

// File: tb/test_sa_rx_table_access.sv
module test_sa_rx_table_access;
  import sa_tbl_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        engineEn;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sa_rx_table_access i_sa_rx_table_access (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .engineEn(engineEn)
  );

  typedef struct {
    bit          isEn;
    logic [3:0]  addr;
    logic [31:0] exp;
    string       tag;
  } sbItem_t;

  sbItem_t sb[$];

  // monitor: compares one tick after the falling edge, where the driver set the address
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        sbItem_t it;
        logic [31:0] got;
        it = sb.pop_front();
        got = it.isEn ? {31'b0, engineEn} : regRdata;
        checks++;
        if (got !== it.exp) begin
          failures++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, got, it.exp);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic busWrite(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
  endtask

  task automatic busIdle();
    @(negedge clk);
    regWrEn = 1'b0; regAddr = ADDR_SPI; regWdata = '0;
  endtask

  task automatic expectReg(logic [3:0] a, logic [31:0] e, string tag);
    sbItem_t it;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = a; regWdata = '0;
    it.isEn = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic expectEn(logic e, string tag);
    sbItem_t it;
    it.isEn = 1'b1; it.addr = '0; it.exp = {31'b0, e}; it.tag = tag;
    sb.push_back(it);
  endtask

  function automatic logic [31:0] cmdWord(logic en, logic [1:0] tbl, int row, logic rd, logic wr);
    logic [9:0] r;
    r = row[9:0];
    return {wr, rd, 17'b0, r, tbl, en};
  endfunction

  // command write plus the execution cycle
  task automatic doCmd(logic en, logic [1:0] tbl, int row, logic rd, logic wr);
    busWrite(ADDR_CMD, cmdWord(en, tbl, row, rd, wr));
    busIdle();
  endtask

  task automatic clearStaging();
    for (int a = 1; a <= 12; a++) busWrite(4'(a), 32'h0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWrEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();

    // R1 reset values
    expectReg(ADDR_CMD, 32'h0, "R1 command");
    expectReg(ADDR_STAT, 32'h0, "R1 status");
    expectReg(ADDR_SPI, 32'h0, "R1 spi staging");
    expectReg(ADDR_MODE, 32'h0, "R1 mode staging");
    expectEn(1'b0, "R1 engineEn");

    // R2 staging readback and masking
    busWrite(ADDR_SPI, 32'h11223344);
    expectReg(ADDR_SPI, 32'h11223344, "R2 spi");
    busWrite(ADDR_MODE, 32'hFFFFFFFF);
    expectReg(ADDR_MODE, 32'h0000001F, "R2 mode mask");
    busWrite(ADDR_IPIDX, 32'hFFFFFF85);
    expectReg(ADDR_IPIDX, 32'h00000005, "R2 ipidx width");
    busWrite(ADDR_KEY0 + 4'd2, 32'hCAFE0002);
    expectReg(ADDR_KEY0 + 4'd2, 32'hCAFE0002, "R2 key word 2");

    // stage full row data
    busWrite(ADDR_SPI, 32'hA1B2C3D4);
    busWrite(ADDR_IPIDX, 32'd5);
    for (int k = 0; k < 4; k++) busWrite(ADDR_KEY0 + 4'(k), 32'hBEEF0000 + 32'(k));
    busWrite(ADDR_SALT, 32'h5A175A17);
    busWrite(ADDR_MODE, 32'h1D);
    for (int k = 0; k < 4; k++) busWrite(ADDR_IP0 + 4'(k), 32'h20010DB0 + 32'(k));

    // R3 / R5 / R9 SPI write at row 3, busy visible in the execution cycle
    busWrite(ADDR_CMD, cmdWord(1'b1, TBL_SPI, 3, 1'b0, 1'b1));
    expectReg(ADDR_STAT, 32'h1, "R5 busy during execution");
    expectReg(ADDR_STAT, 32'h2, "R5 done after execution");
    expectReg(ADDR_CMD, cmdWord(1'b1, TBL_SPI, 3, 1'b0, 1'b0), "R5 strobes cleared");
    expectEn(1'b1, "R9 enable kept");

    doCmd(1'b1, TBL_KEY, 3, 1'b0, 1'b1);
    doCmd(1'b1, TBL_IP, 5, 1'b0, 1'b1);

    // R12 a neighbouring SPI row with another value
    busWrite(ADDR_SPI, 32'h0F0F0F0F);
    doCmd(1'b1, TBL_SPI, 4, 1'b0, 1'b1);

    // R4 read back SPI row 3 into cleared staging; key staging stays zero
    clearStaging();
    doCmd(1'b1, TBL_SPI, 3, 1'b1, 1'b0);
    expectReg(ADDR_SPI, 32'hA1B2C3D4, "R3 spi row stored");
    expectReg(ADDR_IPIDX, 32'd5, "R3 ip index stored");
    expectReg(ADDR_KEY0, 32'h0, "R4 key staging untouched by spi read");
    expectReg(ADDR_IP0, 32'h0, "R4 ip staging untouched by spi read");

    doCmd(1'b1, TBL_KEY, 3, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++)
      expectReg(ADDR_KEY0 + 4'(k), 32'hBEEF0000 + 32'(k), "R3 key word");
    expectReg(ADDR_SALT, 32'h5A175A17, "R3 salt");
    expectReg(ADDR_MODE, 32'h1D, "R3 mode");

    doCmd(1'b1, TBL_IP, 5, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++)
      expectReg(ADDR_IP0 + 4'(k), 32'h20010DB0 + 32'(k), "R3 ip word");

    doCmd(1'b1, TBL_SPI, 4, 1'b1, 1'b0);
    expectReg(ADDR_SPI, 32'h0F0F0F0F, "R12 neighbour row");
    doCmd(1'b1, TBL_SPI, 3, 1'b1, 1'b0);
    expectReg(ADDR_SPI, 32'hA1B2C3D4, "R12 row 3 unchanged");

    // R6 both requests: write wins, staging unchanged
    busWrite(ADDR_SPI, 32'h66667777);
    doCmd(1'b1, TBL_SPI, 7, 1'b1, 1'b1);
    expectReg(ADDR_SPI, 32'h66667777, "R6 staging kept");
    busWrite(ADDR_SPI, 32'h0);
    doCmd(1'b1, TBL_SPI, 7, 1'b1, 1'b0);
    expectReg(ADDR_SPI, 32'h66667777, "R6 row written");

    // R7 IP row 200 aliases row 72 by its low bits; must not reach it
    for (int k = 0; k < 4; k++) busWrite(ADDR_IP0 + 4'(k), 32'h0A000000 + 32'(k));
    doCmd(1'b1, TBL_IP, 72, 1'b0, 1'b1);
    expectReg(ADDR_STAT, 32'h2, "R7 in-range no error");
    for (int k = 0; k < 4; k++) busWrite(ADDR_IP0 + 4'(k), 32'hDEAD0000);
    doCmd(1'b1, TBL_IP, 200, 1'b0, 1'b1);
    expectReg(ADDR_STAT, 32'h6, "R7 error and done");
    doCmd(1'b1, TBL_IP, 72, 1'b1, 1'b0);
    expectReg(ADDR_IP0 + 4'd1, 32'h0A000001, "R7 row 72 unchanged");
    expectReg(ADDR_STAT, 32'h2, "R7 error cleared by next command");

    // R8 table code 00 with a read request
    busWrite(ADDR_SPI, 32'h12121212);
    doCmd(1'b1, TBL_NONE, 3, 1'b1, 1'b0);
    expectReg(ADDR_SPI, 32'h12121212, "R8 staging unchanged");
    expectReg(ADDR_STAT, 32'h2, "R8 done without error");

    // R10 second command during busy is ignored
    busWrite(ADDR_CMD, cmdWord(1'b1, TBL_SPI, 4, 1'b1, 1'b0));
    busWrite(ADDR_CMD, cmdWord(1'b0, TBL_KEY, 9, 1'b0, 1'b1));
    expectReg(ADDR_CMD, cmdWord(1'b1, TBL_SPI, 4, 1'b0, 1'b0), "R10 busy write ignored");
    expectReg(ADDR_SPI, 32'h0F0F0F0F, "R10 first command executed");

    // R9 enable follows a new command write
    doCmd(1'b0, TBL_NONE, 0, 1'b0, 1'b0);
    expectEn(1'b0, "R9 enable cleared by command");

    // R11 storage survives reset
    doReset();
    expectReg(ADDR_SPI, 32'h0, "R1 staging cleared by reset");
    doCmd(1'b0, TBL_SPI, 3, 1'b1, 1'b0);
    expectReg(ADDR_SPI, 32'hA1B2C3D4, "R11 row kept through reset");
    doCmd(1'b0, TBL_KEY, 3, 1'b1, 1'b0);
    expectReg(ADDR_MODE, 32'h1D, "R11 key row kept through reset");

    busIdle();
    busIdle();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule